// File: doc/BRIEF.md
# Segment Register Load Checker

This block checks the load of a 16-bit selector into one segment register and then checks memory offsets against the segment that was loaded. It splits the selector into a requested privilege, a table-select bit and a descriptor index. It bounds-checks the index against the limit of the chosen table. It then fetches the 64-bit descriptor through a simple request/acknowledge memory port and judges the result by type, privilege and presence. On success it keeps the reassembled base, the expanded limit and the write permission, and it reports the descriptor's accessed flag.

A load is started with a one-cycle `ld_valid`. It ends with a one-cycle `ld_ok` or `ld_fault` pulse, and a fault carries a code. While a load is running, the offset checker keeps answering against the segment that is currently held. Each `acc_valid` request gets a response one cycle later, and that response flags offsets past the limit, forbidden writes and use of a null segment.

Top module: `seg_load_checker`

## Requirements
- R1: Selector bits 1..0 are the requested privilege, bit 2 selects the table (0 global, 1 local) and bits 15..3 are the index. The descriptor is read as two 32-bit words: the low word at table base + 8*index, then the high word at that address + 4. Each read holds `mem_req` and a stable `mem_addr` until `mem_ack`.
- R2: If 8*index + 7 exceeds the selected table's limit, the load faults with code 1 and makes no memory request.
- R3: A selector of 0..3 (index 0 in the global table) loaded as data succeeds without any memory read. It leaves `seg_null`=1 with base 0 and limit 0. The same selector loaded as a stack faults with code 1. Index 0 of the local table is not null.
- R4: For a data load, the effective privilege is max(current, requested). If the descriptor privilege (bits 46..45) is below it, the load faults with code 3.
- R5: For a stack load, a descriptor privilege that differs from the current privilege faults with code 3.
- R6: Type is judged from bit 44 (1 = code/data), bit 43 (1 = code) and bit 41 (writable for data, readable for code). A data load needs bit 44 set and either data or readable code. A stack load needs bit 44 set, data and writable. Any other case faults with code 2.
- R7: A clear present bit (bit 47) faults with code 4. When several rules fail, the reported code follows the priority type (2), then privilege (3), then presence (4).
- R8: With granularity bit 55 clear, the limit is the 20-bit field from bits 51..48 and 15..0. With it set, the limit is that field shifted left 12 bits with the low 12 bits all ones (1 gives 1FFFh, 0 gives FFFh).
- R9: The base is reassembled from bits 63..56 and 39..16. `seg_acc` shows bit 40 of the loaded descriptor.
- R10: After reset the held segment is null with base 0 and limit 0. A faulting load leaves base, limit and null state unchanged.
- R11: `acc_resp` follows `acc_valid` by one cycle. `acc_fault` is set if the held segment is null, if the offset is greater than the limit, or if a write targets code or read-only data.
- R12: An access sampled on the same edge that completes a load is judged against the old segment. An access sampled on the following edge is judged against the new one.
- R13: `ld_busy` is high while a fetch is in progress, and `ld_valid` is ignored during that time. Each accepted load produces exactly one completion pulse, and `ld_ok` and `ld_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Start a load (sampled when idle) |
| ld_sel | input | 16 | Selector to load |
| ld_stack | input | 1 | 1 = stack register load, 0 = data register load |
| cur_pl | input | 2 | Current privilege level |
| gbl_base | input | 32 | Global table base address |
| gbl_limit | input | 16 | Global table limit in bytes |
| loc_base | input | 32 | Local table base address |
| loc_limit | input | 16 | Local table limit in bytes |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| ld_busy | output | 1 | Descriptor fetch in progress |
| ld_ok | output | 1 | Load succeeded (one-cycle pulse) |
| ld_fault | output | 1 | Load faulted (one-cycle pulse) |
| ld_code | output | 3 | Fault code: 1 selector/table, 2 type, 3 privilege, 4 not present |
| seg_base | output | 32 | Held segment base |
| seg_limit | output | 32 | Held expanded segment limit |
| seg_null | output | 1 | Held segment is null |
| seg_acc | output | 1 | Accessed flag of held descriptor |
| acc_valid | input | 1 | Offset check request |
| acc_write | input | 1 | Request is a write |
| acc_off | input | 32 | Offset to check |
| acc_resp | output | 1 | Offset check result valid |
| acc_fault | output | 1 | Offset check failed |

## Verification
The offset checker and the load completion can land on the same clock edge, because the segment registers change on the edge that raises `ld_ok`. The bench holds an offset request active on every cycle of a load. The offset chosen lies outside the old limit but inside the new one. Each queued expectation is derived from whether `ld_ok` had already been seen when that request was driven, so the response must flip from fault to pass exactly one request after the completion edge.

// File: rtl/seg_load_checker.sv
module seg_load_checker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_valid,
  input  logic [15:0] ld_sel,
  input  logic        ld_stack,
  input  logic [1:0]  cur_pl,
  input  logic [31:0] gbl_base,
  input  logic [15:0] gbl_limit,
  input  logic [31:0] loc_base,
  input  logic [15:0] loc_limit,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        ld_busy,
  output logic        ld_ok,
  output logic        ld_fault,
  output logic [2:0]  ld_code,
  output logic [31:0] seg_base,
  output logic [31:0] seg_limit,
  output logic        seg_null,
  output logic        seg_acc,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [31:0] acc_off,
  output logic        acc_resp,
  output logic        acc_fault
);

  localparam logic [2:0] FC_NONE = 3'd0;
  localparam logic [2:0] FC_SEL  = 3'd1;
  localparam logic [2:0] FC_TYPE = 3'd2;
  localparam logic [2:0] FC_PRIV = 3'd3;
  localparam logic [2:0] FC_NP   = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI, S_EVAL} st_t;
  st_t st;

  logic        stk_q, seg_wr;
  logic [1:0]  cpl_q, rpl_q;
  logic [31:0] addr_q, lo_q, hi_q;

  // selector decode, used while idle
  logic        sel_null, idx_ovf;
  logic [31:0] tb_base;
  logic [15:0] tb_lim, off;
  assign sel_null = (ld_sel[15:2] == 14'd0);
  assign tb_base  = ld_sel[2] ? loc_base  : gbl_base;
  assign tb_lim   = ld_sel[2] ? loc_limit : gbl_limit;
  assign off      = {ld_sel[15:3], 3'b000};
  assign idx_ovf  = ({1'b0, off} + 17'd7) > {1'b0, tb_lim};

  // descriptor decode, used in evaluation
  logic        d_s, d_x, d_rw, d_p, d_g;
  logic [1:0]  d_dpl, epl;
  logic [19:0] d_lim20;
  logic [31:0] d_base, d_limit;
  logic        type_ok, priv_ok;
  logic [2:0]  chk_code;
  logic        unused_bits;

  assign d_s     = hi_q[12];
  assign d_x     = hi_q[11];
  assign d_rw    = hi_q[9];
  assign d_dpl   = hi_q[14:13];
  assign d_p     = hi_q[15];
  assign d_g     = hi_q[23];
  assign d_lim20 = {hi_q[19:16], lo_q[15:0]};
  assign d_base  = {hi_q[31:24], hi_q[7:0], lo_q[31:16]};
  assign d_limit = d_g ? {d_lim20, 12'hFFF} : {12'h000, d_lim20};
  assign unused_bits = ^{hi_q[10], hi_q[22:20]};

  assign epl     = (cpl_q > rpl_q) ? cpl_q : rpl_q;
  assign type_ok = d_s && (stk_q ? (!d_x && d_rw) : (!d_x || d_rw));
  assign priv_ok = stk_q ? (d_dpl == cpl_q) : (d_dpl >= epl);
  assign chk_code = !type_ok ? FC_TYPE :
                    !priv_ok ? FC_PRIV :
                    !d_p     ? FC_NP   : FC_NONE;

  assign mem_req  = (st == S_LO) || (st == S_HI);
  assign mem_addr = (st == S_HI) ? addr_q + 32'd4 : addr_q;
  assign ld_busy  = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      stk_q     <= 1'b0;
      cpl_q     <= 2'd0;
      rpl_q     <= 2'd0;
      addr_q    <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      ld_ok     <= 1'b0;
      ld_fault  <= 1'b0;
      ld_code   <= FC_NONE;
      seg_base  <= '0;
      seg_limit <= '0;
      seg_null  <= 1'b1;
      seg_wr    <= 1'b0;
      seg_acc   <= 1'b0;
    end else begin
      ld_ok    <= 1'b0;
      ld_fault <= 1'b0;
      case (st)
        S_IDLE: if (ld_valid) begin
          stk_q <= ld_stack;
          cpl_q <= cur_pl;
          rpl_q <= ld_sel[1:0];
          if (sel_null) begin
            if (ld_stack) begin
              ld_fault <= 1'b1;
              ld_code  <= FC_SEL;
            end else begin
              ld_ok     <= 1'b1;
              ld_code   <= FC_NONE;
              seg_base  <= '0;
              seg_limit <= '0;
              seg_null  <= 1'b1;
              seg_wr    <= 1'b0;
              seg_acc   <= 1'b0;
            end
          end else if (idx_ovf) begin
            ld_fault <= 1'b1;
            ld_code  <= FC_SEL;
          end else begin
            addr_q <= tb_base + {16'd0, off};
            st     <= S_LO;
          end
        end
        S_LO: if (mem_ack) begin
          lo_q <= mem_rdata;
          st   <= S_HI;
        end
        S_HI: if (mem_ack) begin
          hi_q <= mem_rdata;
          st   <= S_EVAL;
        end
        default: begin
          st <= S_IDLE;
          if (chk_code != FC_NONE) begin
            ld_fault <= 1'b1;
            ld_code  <= chk_code;
          end else begin
            ld_ok     <= 1'b1;
            ld_code   <= FC_NONE;
            seg_base  <= d_base;
            seg_limit <= d_limit;
            seg_null  <= 1'b0;
            seg_wr    <= !d_x && d_rw;
            seg_acc   <= hi_q[8];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_resp  <= 1'b0;
      acc_fault <= 1'b0;
    end else begin
      acc_resp  <= acc_valid;
      acc_fault <= acc_valid &&
                   (seg_null || (acc_off > seg_limit) || (acc_write && !seg_wr));
    end
  end

  a_r1_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  a_r10_keep_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> $stable(seg_base) && $stable(seg_limit) && $stable(seg_null));

  a_r13_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_ok && ld_fault));

  a_r8_limit_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok && !seg_null |-> (seg_limit[31:20] == 12'd0) || (seg_limit[11:0] == 12'hFFF));

  a_r11_null_faults: assert property (@(posedge clk) disable iff (!rst_n)
    acc_resp && $past(seg_null) |-> acc_fault);

endmodule

// File: tb/seg_load_checker_tb.sv
module seg_load_checker_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ld_valid, ld_stack, mem_ack, acc_valid, acc_write;
  logic [15:0] ld_sel, gbl_limit, loc_limit;
  logic [1:0]  cur_pl;
  logic [31:0] gbl_base, loc_base, mem_rdata, acc_off;
  logic        mem_req, ld_busy, ld_ok, ld_fault, seg_null, seg_acc, acc_resp, acc_fault;
  logic [31:0] mem_addr, seg_base, seg_limit;
  logic [2:0]  ld_code;

  seg_load_checker dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_stack(ld_stack),
    .cur_pl(cur_pl), .gbl_base(gbl_base), .gbl_limit(gbl_limit), .loc_base(loc_base),
    .loc_limit(loc_limit), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ld_busy(ld_busy), .ld_ok(ld_ok), .ld_fault(ld_fault),
    .ld_code(ld_code), .seg_base(seg_base), .seg_limit(seg_limit), .seg_null(seg_null),
    .seg_acc(seg_acc), .acc_valid(acc_valid), .acc_write(acc_write), .acc_off(acc_off),
    .acc_resp(acc_resp), .acc_fault(acc_fault));

  int checks = 0, errors = 0, n_done = 0, rcnt = 0;

  typedef struct { bit ok; logic [2:0] code; logic [31:0] base; logic [31:0] limit; bit nul; string tag; } ld_exp_t;
  typedef struct { bit flt; string tag; } acc_exp_t;
  ld_exp_t  ldq[$];
  acc_exp_t accq[$];
  bit [31:0] mem [bit [31:0]];
  logic [31:0] addr_log[$];

  localparam logic [31:0] GB = 32'h0001_0000;
  localparam logic [31:0] LB = 32'h0002_0000;

  task automatic chk(input bit cond, input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [31:0] b, input logic [19:0] l, input bit g, input bit p,
                                      input logic [1:0] dpl, input bit s, input bit x, input bit rw, input bit a);
    logic [31:0] lo, hi;
    lo = {b[15:0], l[15:0]};
    hi = {b[31:24], g, 3'b000, l[19:16], p, dpl, s, x, 1'b0, rw, a, b[23:16]};
    return {hi, lo};
  endfunction

  task automatic put(input logic [31:0] tb, input int idx, input logic [63:0] d);
    mem[tb + 32'(idx * 8)]     = d[31:0];
    mem[tb + 32'(idx * 8) + 4] = d[63:32];
  endtask

  function automatic logic [15:0] sel(input int idx, input bit ti, input logic [1:0] rpl);
    return {idx[12:0], ti, rpl};
  endfunction

  // memory responder: ack on the second cycle of each request
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      rcnt = 0;
    end else if (mem_req) begin
      rcnt++;
      if (rcnt == 2) begin
        mem_ack = 1'b1;
        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        addr_log.push_back(mem_addr);
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (ld_ok || ld_fault) begin
      n_done++;
      if (ldq.size() == 0) chk(1'b0, "R13", "unexpected completion", {62'd0, ld_ok, ld_fault}, 64'd0);
      else begin
        ld_exp_t e;
        e = ldq.pop_front();
        chk(ld_ok == e.ok && ld_fault == !e.ok, e.tag, "outcome ok", ld_ok, e.ok);
        if (!e.ok) chk(ld_code == e.code, e.tag, "fault code", ld_code, e.code);
        else begin
          chk(seg_base == e.base, e.tag, "base", seg_base, e.base);
          chk(seg_limit == e.limit, e.tag, "limit", seg_limit, e.limit);
          chk(seg_null == e.nul, e.tag, "null", seg_null, e.nul);
        end
      end
    end
    if (acc_resp) begin
      if (accq.size() == 0) chk(1'b0, "R11", "unexpected access response", 1, 0);
      else begin
        acc_exp_t a;
        a = accq.pop_front();
        chk(acc_fault == a.flt, a.tag, "access fault", acc_fault, a.flt);
      end
    end
  end

  task automatic load(input logic [15:0] s, input bit stk, input logic [1:0] cpl, input bit ok,
                      input logic [2:0] code, input logic [31:0] b, input logic [31:0] l, input bit nul, input string tag);
    int start;
    ld_exp_t e;
    e.ok = ok; e.code = code; e.base = b; e.limit = l; e.nul = nul; e.tag = tag;
    ldq.push_back(e);
    start = n_done;
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = s; ld_stack = stk; cur_pl = cpl;
    @(negedge clk);
    ld_valid = 1'b0;
    while (n_done == start) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic access(input logic [31:0] o, input bit wr, input bit flt, input string tag);
    acc_exp_t a;
    a.flt = flt; a.tag = tag;
    accq.push_back(a);
    @(negedge clk);
    acc_valid = 1'b1; acc_off = o; acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n0;
    bit upd, saw_old, saw_new;
    rst_n = 1'b0; ld_valid = 1'b0; ld_sel = '0; ld_stack = 1'b0; cur_pl = 2'd0;
    mem_ack = 1'b0; mem_rdata = '0; acc_valid = 1'b0; acc_write = 1'b0; acc_off = '0;
    gbl_base = GB; gbl_limit = 16'h00FF; loc_base = LB; loc_limit = 16'h003F;

    put(GB, 1,  mkd(32'h1234_5678, 20'h00ABC, 0, 1, 2'd3, 1, 0, 1, 1));
    put(LB, 2,  mkd(32'hA000_0000, 20'h00001, 1, 1, 2'd3, 1, 0, 1, 0));
    put(GB, 3,  mkd(32'h0040_0000, 20'h00000, 1, 1, 2'd3, 1, 0, 0, 0));
    put(GB, 4,  mkd(32'h0000_1000, 20'h000FF, 0, 1, 2'd1, 1, 0, 1, 0));
    put(GB, 5,  mkd(32'h0000_2000, 20'h001FF, 0, 1, 2'd2, 1, 0, 1, 0));
    put(GB, 6,  mkd(32'h0000_2800, 20'h0007F, 0, 1, 2'd3, 1, 1, 0, 0));
    put(GB, 7,  mkd(32'h0000_3000, 20'h0007F, 0, 1, 2'd3, 1, 1, 1, 0));
    put(GB, 8,  mkd(32'h0000_3800, 20'h0007F, 0, 1, 2'd3, 0, 0, 1, 0));
    put(GB, 9,  mkd(32'h0000_4000, 20'h0007F, 0, 0, 2'd3, 1, 0, 1, 0));
    put(GB, 10, mkd(32'h0000_4800, 20'h0007F, 0, 0, 2'd0, 1, 0, 1, 0));
    put(GB, 11, mkd(32'h0000_4C00, 20'h0007F, 0, 0, 2'd0, 1, 1, 0, 0));
    put(GB, 12, mkd(32'h0000_9000, 20'h00FFF, 0, 1, 2'd3, 1, 0, 1, 0));
    put(LB, 0,  mkd(32'h0000_5000, 20'h00010, 0, 1, 2'd3, 1, 0, 1, 0));
    put(GB, 31, mkd(32'h0000_7000, 20'h00020, 0, 1, 2'd3, 1, 0, 1, 0));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(seg_null == 1'b1 && seg_base == 0 && seg_limit == 0, "R10", "reset segment", {seg_null, seg_base}, {1'b1, 32'd0});
    chk(!ld_ok && !ld_fault && !mem_req && !ld_busy, "R13", "reset idle", {ld_ok, ld_fault, mem_req, ld_busy}, 0);
    access(32'h0, 1'b0, 1'b1, "R11 reset null access");

    // R1 / R9: global data descriptor
    addr_log.delete();
    load(sel(1, 0, 0), 0, 2'd0, 1, 0, 32'h1234_5678, 32'h0000_0ABC, 0, "R9 gdt data");
    chk(addr_log.size() == 2, "R1", "read count", addr_log.size(), 2);
    if (addr_log.size() == 2) begin
      chk(addr_log[0] == 32'h0001_0008, "R1", "low word addr", addr_log[0], 32'h0001_0008);
      chk(addr_log[1] == 32'h0001_000C, "R1", "high word addr", addr_log[1], 32'h0001_000C);
    end
    chk(seg_acc == 1'b1, "R9", "accessed flag", seg_acc, 1);
    access(32'hABC, 0, 0, "R11 read at limit");
    access(32'hABD, 0, 1, "R11 read past limit");
    access(32'hABC, 1, 0, "R11 write writable data");
    load(sel(1, 0, 3), 0, 2'd0, 1, 0, 32'h1234_5678, 32'h0000_0ABC, 0, "R4 rpl3 dpl3");

    // R8: granularity
    addr_log.delete();
    load(sel(2, 1, 0), 0, 2'd0, 1, 0, 32'hA000_0000, 32'h0000_1FFF, 0, "R8 g limit 1");
    if (addr_log.size() == 2) chk(addr_log[0] == 32'h0002_0010, "R1", "local table addr", addr_log[0], 32'h0002_0010);
    else chk(1'b0, "R1", "local read count", addr_log.size(), 2);
    chk(seg_acc == 1'b0, "R9", "accessed clear", seg_acc, 0);
    load(sel(3, 0, 0), 0, 2'd0, 1, 0, 32'h0040_0000, 32'h0000_0FFF, 0, "R8 g limit 0");
    access(32'hFFF, 0, 0, "R11 read ro at limit");
    access(32'h1000, 0, 1, "R11 read past ro limit");
    access(32'h10, 1, 1, "R11 write read-only data");

    // R4 / R10: data privilege
    load(sel(4, 0, 2), 0, 2'd0, 0, 3'd3, 0, 0, 0, "R4 rpl raises epl");
    chk(seg_base == 32'h0040_0000 && seg_limit == 32'hFFF, "R10", "kept after fault", seg_base, 32'h0040_0000);
    load(sel(4, 0, 0), 0, 2'd2, 0, 3'd3, 0, 0, 0, "R4 cpl raises epl");
    load(sel(4, 0, 1), 0, 2'd1, 1, 0, 32'h1000, 32'hFF, 0, "R4 epl equals dpl");
    load(sel(4, 0, 0), 0, 2'd0, 1, 0, 32'h1000, 32'hFF, 0, "R4 epl below dpl");

    // R5 / R6 / R7: stack rules
    load(sel(5, 0, 2), 1, 2'd2, 1, 0, 32'h2000, 32'h1FF, 0, "R5 stack dpl=cpl");
    load(sel(5, 0, 0), 1, 2'd0, 0, 3'd3, 0, 0, 0, "R5 stack dpl!=cpl");
    load(sel(3, 0, 3), 1, 2'd3, 0, 3'd2, 0, 0, 0, "R6 stack read-only");
    load(sel(9, 0, 3), 1, 2'd3, 0, 3'd4, 0, 0, 0, "R7 stack not present");

    // R6: types for data loads
    load(sel(6, 0, 3), 0, 2'd3, 0, 3'd2, 0, 0, 0, "R6 exec-only code");
    load(sel(7, 0, 3), 0, 2'd3, 1, 0, 32'h3000, 32'h7F, 0, "R6 readable code");
    access(32'h7F, 0, 0, "R11 read code");
    access(32'h10, 1, 1, "R11 write code");
    load(sel(8, 0, 3), 0, 2'd3, 0, 3'd2, 0, 0, 0, "R6 system descriptor");

    // R7: presence and priority
    load(sel(9, 0, 3), 0, 2'd3, 0, 3'd4, 0, 0, 0, "R7 not present");
    load(sel(10, 0, 3), 0, 2'd3, 0, 3'd3, 0, 0, 0, "R7 priv before present");
    load(sel(11, 0, 3), 0, 2'd3, 0, 3'd2, 0, 0, 0, "R7 type before priv");

    // R3: null selector
    n0 = addr_log.size();
    load(16'h0003, 0, 2'd0, 1, 0, 32'h0, 32'h0, 1, "R3 null data");
    chk(addr_log.size() == n0, "R3", "no read for null", addr_log.size(), n0);
    access(32'h0, 0, 1, "R3 access via null");
    load(16'h0000, 1, 2'd0, 0, 3'd1, 0, 0, 0, "R3 null stack");
    load(16'h0004, 0, 2'd0, 1, 0, 32'h5000, 32'h10, 0, "R3 local index 0");

    // R2: table limit
    n0 = addr_log.size();
    load(sel(32, 0, 0), 0, 2'd0, 0, 3'd1, 0, 0, 0, "R2 global past limit");
    load(sel(8, 1, 0), 0, 2'd0, 0, 3'd1, 0, 0, 0, "R2 local past limit");
    chk(addr_log.size() == n0, "R2", "no reads on table fault", addr_log.size(), n0);
    load(sel(31, 0, 0), 0, 2'd0, 1, 0, 32'h7000, 32'h20, 0, "R2 last global entry");

    // R12: access concurrent with load completion
    load(sel(1, 0, 0), 0, 2'd0, 1, 0, 32'h1234_5678, 32'h0000_0ABC, 0, "R12 old segment");
    begin
      ld_exp_t e;
      acc_exp_t a;
      e.ok = 1; e.code = 0; e.base = 32'h9000; e.limit = 32'hFFF; e.nul = 0; e.tag = "R12 new segment";
      ldq.push_back(e);
      upd = 0; saw_old = 0; saw_new = 0;
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = sel(12, 0, 0); ld_stack = 0; cur_pl = 0;
      acc_valid = 1'b1; acc_off = 32'hF00; acc_write = 1'b0;
      a.flt = 1; a.tag = "R12 same-edge access"; accq.push_back(a); saw_old = 1;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        ld_valid = 1'b0;
        if (ld_ok) upd = 1;
        a.flt = !upd; a.tag = "R12 concurrent access"; accq.push_back(a);
        if (upd) saw_new = 1;
      end
      @(negedge clk);
      acc_valid = 1'b0;
      @(negedge clk);
      chk(saw_old && saw_new, "R12", "both phases seen", {saw_old, saw_new}, 2'b11);
    end

    // R13: ld_valid during fetch ignored
    n0 = n_done;
    begin
      ld_exp_t e;
      e.ok = 1; e.code = 0; e.base = 32'h1234_5678; e.limit = 32'hABC; e.nul = 0; e.tag = "R13 busy load";
      ldq.push_back(e);
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = sel(1, 0, 0); ld_stack = 0; cur_pl = 0;
      @(negedge clk);
      ld_valid = 1'b0;
      @(negedge clk);
      chk(ld_busy == 1'b1, "R13", "busy during fetch", ld_busy, 1);
      ld_valid = 1'b1; ld_sel = 16'hFFF8; ld_stack = 1;
      @(negedge clk);
      ld_valid = 1'b0;
      while (n_done == n0) @(negedge clk);
      repeat (6) @(negedge clk);
      chk(n_done == n0 + 1, "R13", "single completion", n_done, n0 + 1);
    end

    chk(ldq.size() == 0 && accq.size() == 0, "R11", "queues drained", ldq.size() + accq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule